// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block decides who owns an external memory bus: the local bus master or an external device. The external device asks for the bus by pulling an active-low request low. The block answers with an active-low acknowledge, and only at a bus-cycle boundary reported by the local cycle sequencer. While the external device holds the bus, the local bus drivers are turned off. A stall output tells the sequencer not to start new cycles from the moment a request is seen until the bus has been handed back.

Firmware turns the protocol on and off through one bit of a control byte. Turning it on also locks the three shared pins (request, acknowledge and local bus-request) in their hold function until the next reset. Turning it off is deferred. A hold that is already running is served until the external device lets go, and requests after that are ignored. A pin-status readback shows the live levels of the shared pins while they are locked.

All timing advances on phase ticks of half a state time. This lets half-state latencies be expressed. The request input first passes through a synchroniser.

Top module: `bus_hold_arb`

## Requirements
- R1: After reset, hold_ack_no=1, bus_drv_en_o=1, hold_stall_o=0, bus_req_no=1 and lock_o=0.
- R2: While the hold-enable bit is clear, a low hold_req_ni causes no acknowledge and no stall, and the local drivers stay enabled.
- R3: A control write with bit 7 of ctrl_wdata_i set raises lock_o. lock_o stays high through any later write, including one that clears bit 7, and only reset clears it.
- R4: hold_ack_no falls only at a phase tick where bus_idle_i is high. It is never low while a local bus cycle is still running.
- R5: The delay from a request to the acknowledge is at least three clocks (the synchroniser). With the sequencer idle it is at most 3 phases. With 16-bit cycles of 2+2w phases it is at most 5+2w phases, and with 8-bit cycles of 4+4w phases at most 5+4w phases (w = wait states).
- R6: bus_drv_en_o is low whenever hold_ack_no is low.
- R7: On the first phase tick after the synchronised request goes high, hold_ack_no rises while the drivers stay off. bus_drv_en_o rises exactly one phase later.
- R8: Clearing the enable bit (bit 7 written 0) during a granted hold does not end it. The acknowledge stays low until the request is released.
- R9: After a deferred disable has taken effect, new requests are ignored until bit 7 is written 1 again. After that they are granted.
- R10: While lock_o=1, pin_stat_o is {bus_req_no, hold_ack_no, synchronised request level}, with bit 0 the request. While lock_o=0, pin_stat_o is 0.
- R11: bus_req_no is low exactly when the bus is granted and local_req_i is high.
- R12: A request withdrawn before it is granted produces no acknowledge. hold_stall_o is high while such a request waits, and low once it is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_tick_i | input | 1 | One-clock pulse per half state time |
| hold_req_ni | input | 1 | Asynchronous hold request from the external device, active low |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | CTRL_W | Control byte; bit EN_BIT (7) is hold enable |
| bus_idle_i | input | 1 | Sequencer is at a cycle boundary (no cycle, or the last phase of one) |
| local_req_i | input | 1 | Local master wants the bus back during a hold |
| hold_ack_no | output | 1 | Hold acknowledge, active low |
| bus_drv_en_o | output | 1 | Local bus driver enable |
| hold_stall_o | output | 1 | Sequencer must not start a new cycle |
| bus_req_no | output | 1 | Local bus request to the holder, active low |
| lock_o | output | 1 | Shared pins locked to hold function |
| pin_stat_o | output | 3 | Live shared-pin levels readback |

## Verification
The bench runs the sequencer in idle, 16-bit and 8-bit modes with 0 to 3 wait states. It places each request at a random offset against the running cycles and measures the delay to the acknowledge. A design that grants in mid-cycle is caught by a monitor that flags an acknowledge during a live cycle. A design that leaves out the stall or loses a synchroniser stage breaks the latency bounds. The release order is timed to the clock: a design that re-enables the drivers together with the acknowledge would have both masters driving the bus, and is caught. A disable written during a hold must not cut the hold short, yet must then shut out later requests. A request withdrawn before its boundary must leave no acknowledge behind. The lock must survive a disabling write and clear only on reset.

// File: rtl/bha_pkg.sv
package bha_pkg;
  localparam int unsigned PIN_N = 3;

  typedef enum logic [1:0] {
    ST_OWN   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_GRANT = 2'd2,
    ST_REL   = 2'd3
  } hold_st_e;
endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/bha_ctrl.sv
module bha_ctrl #(
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned EN_BIT = 7,
  parameter int unsigned PIN_N  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              req_sync_ni,
  input  logic              ack_ni,
  input  logic              bus_req_ni,
  output logic              en_o,
  output logic              lock_o,
  output logic [PIN_N-1:0]  pin_stat_o
);
  localparam logic [CTRL_W-1:0] EN_MASK = CTRL_W'(1) << EN_BIT;

  logic en_q, lock_q;
  logic unused_wdata;

  assign unused_wdata = ^(wdata_i & ~EN_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
    end else if (we_i) begin
      en_q <= wdata_i[EN_BIT];
      if (wdata_i[EN_BIT]) lock_q <= 1'b1;
    end
  end

  assign en_o   = en_q;
  assign lock_o = lock_q;

  // shared-pin readback order: request, acknowledge, local bus request
  always_comb begin
    pin_stat_o = '0;
    if (lock_q) pin_stat_o = PIN_N'({bus_req_ni, ack_ni, req_sync_ni});
  end
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
  import bha_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic req_i,
  input  logic en_i,
  input  logic bus_idle_i,
  input  logic local_req_i,
  output logic ack_no,
  output logic drv_en_o,
  output logic stall_o,
  output logic bus_req_no
);
  hold_st_e st_q, st_d;

  // enable is consulted only when the local master owns the bus:
  // a clear during a hold is thereby deferred to its end
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_OWN:   if (req_i && en_i) st_d = bus_idle_i ? ST_GRANT : ST_WAIT;
      ST_WAIT:  if (!req_i)        st_d = ST_OWN;
                else if (bus_idle_i) st_d = ST_GRANT;
      ST_GRANT: if (!req_i)        st_d = ST_REL;
      ST_REL:                      st_d = ST_OWN;
      default:                     st_d = ST_OWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= ST_OWN;
    else if (tick_i) st_q <= st_d;
  end

  assign ack_no     = (st_q != ST_GRANT);
  assign drv_en_o   = (st_q == ST_OWN) || (st_q == ST_WAIT);
  assign stall_o    = (st_q != ST_OWN) || (req_i && en_i);
  assign bus_req_no = !((st_q == ST_GRANT) && local_req_i);
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
  import bha_pkg::*;
#(
  parameter int unsigned CTRL_W      = 8,
  parameter int unsigned EN_BIT      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phase_tick_i,
  input  logic              hold_req_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              bus_idle_i,
  input  logic              local_req_i,
  output logic              hold_ack_no,
  output logic              bus_drv_en_o,
  output logic              hold_stall_o,
  output logic              bus_req_no,
  output logic              lock_o,
  output logic [PIN_N-1:0]  pin_stat_o
);
  logic req_sync_n;
  logic hold_en;

  bha_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (hold_req_ni),
    .q_o    (req_sync_n)
  );

  bha_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (phase_tick_i),
    .req_i       (!req_sync_n),
    .en_i        (hold_en),
    .bus_idle_i  (bus_idle_i),
    .local_req_i (local_req_i),
    .ack_no      (hold_ack_no),
    .drv_en_o    (bus_drv_en_o),
    .stall_o     (hold_stall_o),
    .bus_req_no  (bus_req_no)
  );

  bha_ctrl #(
    .CTRL_W (CTRL_W),
    .EN_BIT (EN_BIT),
    .PIN_N  (PIN_N)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctrl_we_i),
    .wdata_i     (ctrl_wdata_i),
    .req_sync_ni (req_sync_n),
    .ack_ni      (hold_ack_no),
    .bus_req_ni  (bus_req_no),
    .en_o        (hold_en),
    .lock_o      (lock_o),
    .pin_stat_o  (pin_stat_o)
  );
endmodule

// File: rtl/bus_hold_arb_chk.sv
module bus_hold_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       phase_tick_i,
  input logic       bus_idle_i,
  input logic       hold_ack_no,
  input logic       bus_drv_en_o,
  input logic       bus_req_no,
  input logic       lock_o,
  input logic [2:0] pin_stat_o
);
  // R6
  ack_drv_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ack_no |-> !bus_drv_en_o);

  // R4
  grant_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_ack_no) |-> $past(phase_tick_i && bus_idle_i));

  // R7
  drv_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_drv_en_o) |-> ($past(hold_ack_no) && $past(phase_tick_i)));

  // R7
  ack_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hold_ack_no) |-> $past(phase_tick_i));

  // R3
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);

  // R11
  breq_in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_no |-> !hold_ack_no);

  // R10
  pin_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> (pin_stat_o[1] == hold_ack_no && pin_stat_o[2] == bus_req_no));

  // R10
  unlocked_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |-> (pin_stat_o == 3'b000));
endmodule

bind bus_hold_arb bus_hold_arb_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .phase_tick_i (phase_tick_i),
  .bus_idle_i   (bus_idle_i),
  .hold_ack_no  (hold_ack_no),
  .bus_drv_en_o (bus_drv_en_o),
  .bus_req_no   (bus_req_no),
  .lock_o       (lock_o),
  .pin_stat_o   (pin_stat_o)
);

// File: tb/bus_hold_arb_bench.sv
`timescale 1ns/1ps
module bus_hold_arb_bench;
  localparam int P = 4;  // clocks per phase tick

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       phase_tick = 1'b0;
  logic       hold_req_n = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       bus_idle;
  logic       local_req = 1'b0;
  logic       hold_ack_n, bus_drv_en, hold_stall, bus_req_n, lock;
  logic [2:0] pin_stat;

  int n_chk = 0;
  int n_fail = 0;
  int seq_mode = 0;
  int seq_w = 0;
  int seq_rem = 0;
  logic [1:0] tcnt = 2'd0;

  bus_hold_arb u_bus_hold_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_tick_i (phase_tick),
    .hold_req_ni  (hold_req_n),
    .ctrl_we_i    (ctrl_we),
    .ctrl_wdata_i (ctrl_wdata),
    .bus_idle_i   (bus_idle),
    .local_req_i  (local_req),
    .hold_ack_no  (hold_ack_n),
    .bus_drv_en_o (bus_drv_en),
    .hold_stall_o (hold_stall),
    .bus_req_no   (bus_req_n),
    .lock_o       (lock),
    .pin_stat_o   (pin_stat)
  );

  always #2 clk_i = ~clk_i;

  function automatic int cyc_len(int m, int w);
    if (m == 1) return 2 + 2 * w;
    if (m == 2) return 4 + 4 * w;
    return 0;
  endfunction

  function automatic int bound_ph(int m, int w);
    if (m == 1) return 5 + 2 * w;
    if (m == 2) return 5 + 4 * w;
    return 3;
  endfunction

  // phase tick and sequencer model
  always @(posedge clk_i) begin
    tcnt       <= tcnt + 2'd1;
    phase_tick <= (tcnt == 2'd3);
  end

  assign bus_idle = (seq_rem <= 1);

  always @(posedge clk_i) begin
    if (phase_tick) begin
      if (seq_rem > 1) seq_rem <= seq_rem - 1;
      else if (seq_mode != 0 && !hold_stall && bus_drv_en) seq_rem <= cyc_len(seq_mode, seq_w);
      else seq_rem <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R4: acknowledge during a live cycle
  always @(negedge clk_i) begin
    if (rst_ni && !hold_ack_n && seq_rem != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 grant during cycle actual=%0d expected=0", seq_rem);
    end
  end

  task automatic wait_ph(input int n);
    repeat (n * P) @(negedge clk_i);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk_i);
    ctrl_we = 1'b1;
    ctrl_wdata = d;
    @(negedge clk_i);
    ctrl_we = 1'b0;
  endtask

  task automatic watch_no_ack(input int phases, output bit acked);
    acked = 1'b0;
    repeat (phases * P) begin
      @(negedge clk_i);
      if (!hold_ack_n) acked = 1'b1;
    end
  endtask

  task automatic grant_trial(input int m, input int w, input bit lreq);
    int lat;
    int hold_ph;
    int gap;
    seq_mode = m;
    seq_w = w;
    wait_ph(20);
    repeat ($urandom_range(0, 7)) @(negedge clk_i);
    local_req = lreq;
    hold_req_n = 1'b0;
    lat = 0;
    while (hold_ack_n && lat < 300) begin
      @(negedge clk_i);
      lat++;
    end
    chk(!hold_ack_n && lat >= 3 && lat <= bound_ph(m, w) * P, "R5 grant latency", lat, bound_ph(m, w) * P);
    chk(seq_rem == 0, "R4 grant at boundary", seq_rem, 0);
    chk(!bus_drv_en, "R6 drivers off in hold", int'(bus_drv_en), 0);
    chk(bus_req_n == !lreq, "R11 local bus request", int'(bus_req_n), int'(!lreq));
    hold_ph = $urandom_range(1, 4);
    wait_ph(hold_ph);
    hold_req_n = 1'b1;
    lat = 0;
    while (!hold_ack_n && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
    chk(hold_ack_n && lat <= P + 3, "R7 ack release", lat, P + 3);
    chk(!bus_drv_en, "R7 drivers off at ack release", int'(bus_drv_en), 0);
    gap = 0;
    while (!bus_drv_en && gap < 100) begin
      @(negedge clk_i);
      gap++;
    end
    chk(gap == P, "R7 driver re-enable gap", gap, P);
    local_req = 1'b0;
  endtask

  initial begin
    bit acked;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1
    chk(hold_ack_n && bus_drv_en && !hold_stall && bus_req_n && !lock, "R1 reset state",
        int'({hold_ack_n, bus_drv_en, hold_stall, bus_req_n, lock}), 5'b11010);
    // R10
    chk(pin_stat == 3'b000, "R10 unlocked readback", int'(pin_stat), 0);

    // R2: disabled protocol ignores requests
    seq_mode = 1;
    seq_w = 1;
    hold_req_n = 1'b0;
    watch_no_ack(20, acked);
    chk(!acked, "R2 no ack while disabled", int'(acked), 0);
    chk(!hold_stall && bus_drv_en, "R2 no stall while disabled", int'({hold_stall, bus_drv_en}), 1);
    hold_req_n = 1'b1;
    wait_ph(3);

    // R3
    wr_ctrl(8'h80);
    chk(lock, "R3 lock on enable", int'(lock), 1);
    wr_ctrl(8'h00);
    chk(lock, "R3 lock after disable write", int'(lock), 1);
    wr_ctrl(8'h80);
    wait_ph(2);
    // R10
    chk(pin_stat == 3'b111, "R10 idle readback", int'(pin_stat), 7);

    for (int i = 0; i < 36; i++)
      grant_trial(int'($urandom_range(0, 2)), int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)));
    grant_trial(2, 3, 1'b1);
    grant_trial(1, 0, 1'b0);
    grant_trial(0, 0, 1'b1);
    grant_trial(1, 3, 1'b0);

    // R10 during a hold, local request off
    seq_mode = 0;
    wait_ph(4);
    hold_req_n = 1'b0;
    wait_ph(4);
    chk(pin_stat == 3'b100, "R10 hold readback", int'(pin_stat), 4);

    // R8: deferred disable, other bits set
    wr_ctrl(8'h7F);
    wait_ph(8);
    chk(!hold_ack_n && !bus_drv_en, "R8 hold kept after disable", int'({hold_ack_n, bus_drv_en}), 0);
    hold_req_n = 1'b1;
    wait_ph(3);
    chk(hold_ack_n && bus_drv_en, "R8 bus reclaimed on release", int'({hold_ack_n, bus_drv_en}), 3);

    // R9: new requests ignored, then honoured after re-enable
    hold_req_n = 1'b0;
    watch_no_ack(20, acked);
    chk(!acked, "R9 request ignored after disable", int'(acked), 0);
    chk(!hold_stall, "R9 no stall after disable", int'(hold_stall), 0);
    chk(lock, "R3 lock held after disable", int'(lock), 1);
    hold_req_n = 1'b1;
    wait_ph(2);
    wr_ctrl(8'h80);
    hold_req_n = 1'b0;
    wait_ph(4);
    chk(!hold_ack_n, "R9 request honoured after re-enable", int'(hold_ack_n), 0);
    hold_req_n = 1'b1;
    wait_ph(3);

    // R12: withdrawn request
    seq_mode = 2;
    seq_w = 3;
    wait_ph(2);
    while (seq_rem != cyc_len(2, 3)) @(negedge clk_i);
    hold_req_n = 1'b0;
    wait_ph(3);
    chk(hold_stall && hold_ack_n, "R12 stall while waiting", int'({hold_stall, hold_ack_n}), 3);
    hold_req_n = 1'b1;
    watch_no_ack(20, acked);
    chk(!acked, "R12 no ack after withdraw", int'(acked), 0);
    chk(!hold_stall, "R12 stall cleared", int'(hold_stall), 0);
    seq_mode = 0;
    wait_ph(20);

    // R3: reset clears lock
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!lock, "R3 lock cleared by reset", int'(lock), 0);
    chk(hold_ack_n && bus_drv_en, "R1 state after second reset", int'({hold_ack_n, bus_drv_en}), 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule